// File: doc/BRIEF.md
# Staged Secure Boot Sequencer

This controller rebuilds a reconfigurable device in stages after power-up. It reads an external configuration memory one word at a time. The memory holds five segments back to back, and they are loaded in a fixed order. First a decryption engine image is loaded into a shared engine region. Then an encrypted critical module is passed through that engine. A second engine image then overwrites the first one in the same region. A second encrypted module follows through the new engine. Last, a plain non-critical module takes over the shared region. This lets the chip swap its own decryption logic part-way through boot, so each critical module can use a different cipher and no engine stays resident once boot ends.

Each segment starts with a header word and ends with a signature word. The controller checks that signature before it moves on. Each encrypted segment gets its own key, which is sliced out of a 1024-bit device master key by the header's key index. The key is held on the engine port for the whole segment. Plain words go straight to the configuration port. Encrypted words make a round trip through the engine first. Every transfer uses a valid/ready handshake, so a slow configuration port only stalls the controller and never loses a word. A failed check stops the boot for good and reports the failing segment. A full boot ends with a single-cycle completion pulse.

Top module: `stage_boot_seq`

## Requirements
- R1: Header word layout: bits [31:30] hold the segment type (0 = plain engine image, 1 = encrypted module, 2 = plain non-critical module), bits [29:27] hold the key index, and bits [23:0] hold the body word count. Segments 0..4 must carry the types 0,1,0,1,2 in that order. A header with the wrong type stops the boot with an error, and none of that segment's words are written.
- R2: Body words of segments 0 and 2 are written unchanged to the configuration port, in memory order, with region code 0 (the shared engine region).
- R3: Each body word of segments 1 and 3 is offered to the engine on dec_valid/dec_data. The engine's reply is what gets written, with region code 1 for segment 1 and region code 2 for segment 3. dec_valid and cfg_valid are never high together.
- R4: Body words of segment 4 are written unchanged with region code 0, so they replace the last engine image.
- R5: During an encrypted segment, dec_key equals master_key[128*k +: 128], where k is that segment's key index, and it does not change while words of that segment are offered.
- R6: The word after each body is the signature. The running value starts at 0 and takes s = rotate-left-by-1(s) XOR w for the header and then every body word, as stored. A mismatch stops the boot with an error.
- R7: While cfg_valid is high and cfg_ready is low, cfg_data and cfg_region hold. Every body word is written exactly once.
- R8: Memory reads start at address 0 and step by one on each accepted read. mem_addr holds while mem_req waits for mem_ack.
- R9: After an error, boot_err stays high, err_seg gives the index of the failing segment, and mem_req, cfg_valid and dec_valid stay low.
- R10: boot_done is high for exactly one cycle, after segment 4's signature has matched and all of its words have been written. It is never high on a boot that failed.
- R11: Reset clears boot_err and restarts the boot at segment 0 and address 0. This includes a reset in the middle of a boot and a reset after an error.
- R12: A segment with a body count of 0 goes from its header straight to its signature and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request to configuration memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_ack | input | 1 | Read accepted; mem_rdata valid this cycle |
| mem_rdata | input | WORD_W | Read data |
| cfg_valid | output | 1 | Configuration write offered |
| cfg_ready | input | 1 | Configuration port accepts the word |
| cfg_data | output | WORD_W | Configuration word |
| cfg_region | output | 2 | Target region: 0 shared, 1 module slot 1, 2 module slot 2 |
| dec_valid | output | 1 | Cipher word offered to the engine |
| dec_ready | input | 1 | Engine accepts the cipher word |
| dec_data | output | WORD_W | Cipher word |
| dec_key | output | KEY_W | Derived key for the current encrypted segment |
| dec_res_valid | input | 1 | Engine returns a plain word |
| dec_res_data | input | WORD_W | Plain word from the engine |
| master_key | input | MASTER_W | Device master key |
| boot_done | output | 1 | One-cycle completion pulse |
| boot_err | output | 1 | Sticky error flag |
| err_seg | output | 3 | Index of the failing segment |

## Verification
The hardest state to reach is a stall that lands at the handoff between two engines. Segment 1's last word may still be waiting on the engine or the configuration port while the next header, with a new key index, is already due. Random back-pressure on all three handshakes, together with very short bodies (one word) and empty bodies, packs these boundaries close together. Signature and type faults are injected into chosen segments, including the last one. This checks that words written before the fault are exactly the expected prefix and that nothing moves afterwards.

// File: rtl/stage_boot_pkg.sv
package stage_boot_pkg;

    localparam int SEG_W = 3;
    localparam logic [SEG_W-1:0] LAST_SEG = 3'd4;

    localparam logic [1:0] TYPE_ENGINE = 2'd0;
    localparam logic [1:0] TYPE_CIPHER = 2'd1;
    localparam logic [1:0] TYPE_PLAIN  = 2'd2;

    localparam logic [1:0] REGION_SHARED = 2'd0;
    localparam logic [1:0] REGION_SLOT1  = 2'd1;
    localparam logic [1:0] REGION_SLOT2  = 2'd2;

    typedef enum logic [2:0] {
        PH_HDR,
        PH_BODY,
        PH_DSEND,
        PH_DWAIT,
        PH_CFG,
        PH_SIG,
        PH_FIN,
        PH_ERR
    } phase_t;

endpackage

// File: rtl/seg_plan.sv
module seg_plan
    import stage_boot_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    output logic [1:0]       exp_type,
    output logic [1:0]       region
);
    always_comb begin
        unique case (seg)
            3'd0, 3'd2: begin exp_type = TYPE_ENGINE; region = REGION_SHARED; end
            3'd1:       begin exp_type = TYPE_CIPHER; region = REGION_SLOT1;  end
            3'd3:       begin exp_type = TYPE_CIPHER; region = REGION_SLOT2;  end
            default:    begin exp_type = TYPE_PLAIN;  region = REGION_SHARED; end
        endcase
    end
endmodule

// File: rtl/key_select.sv
module key_select #(
    parameter int MASTER_W = 1024,
    parameter int KEY_W    = 128,
    localparam int NUM_KEYS = MASTER_W / KEY_W,
    localparam int KIDX_W   = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [KIDX_W-1:0]   idx,
    input  logic [MASTER_W-1:0] master_key,
    output logic [KEY_W-1:0]    key
);
    logic [KEY_W-1:0] slice [NUM_KEYS];
    logic [KEY_W-1:0] key_d, key_q;

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slice
        assign slice[g] = master_key[g*KEY_W +: KEY_W];
    end

    always_comb begin
        key_d = key_q;
        if (load) key_d = slice[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign key = key_q;
endmodule

// File: rtl/sig_accum.sv
module sig_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         update,
    input  logic [W-1:0] word,
    output logic [W-1:0] sig
);
    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (start)       sig_d = word;
        else if (update) sig_d = {sig_q[W-2:0], sig_q[W-1]} ^ word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig = sig_q;
endmodule

// File: rtl/stage_boot_seq.sv
module stage_boot_seq
    import stage_boot_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 24,
    parameter int KEY_W    = 128,
    parameter int MASTER_W = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                cfg_valid,
    input  logic                cfg_ready,
    output logic [WORD_W-1:0]   cfg_data,
    output logic [1:0]          cfg_region,
    output logic                dec_valid,
    input  logic                dec_ready,
    output logic [WORD_W-1:0]   dec_data,
    output logic [KEY_W-1:0]    dec_key,
    input  logic                dec_res_valid,
    input  logic [WORD_W-1:0]   dec_res_data,
    input  logic [MASTER_W-1:0] master_key,
    output logic                boot_done,
    output logic                boot_err,
    output logic [2:0]          err_seg
);
    localparam int NUM_KEYS = MASTER_W / KEY_W;
    localparam int KIDX_W   = $clog2(NUM_KEYS);
    localparam int TYPE_HI  = WORD_W - 1;
    localparam int KIDX_HI  = WORD_W - 3;
    localparam int SPARE_HI = WORD_W - 3 - KIDX_W;

    typedef struct packed {
        phase_t             phase;
        logic [SEG_W-1:0]   seg;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  word;
        logic               enc;
        logic               done;
        logic               err;
        logic [SEG_W-1:0]   err_seg;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [1:0]        hdr_type;
    logic [KIDX_W-1:0] hdr_kidx;
    logic [CNT_W-1:0]  hdr_cnt;
    logic              hdr_unused;
    logic [1:0]        exp_type;
    logic [1:0]        region;
    logic              sig_start, sig_update, key_load;
    logic [WORD_W-1:0] sig;

    assign hdr_type   = mem_rdata[TYPE_HI -: 2];
    assign hdr_kidx   = mem_rdata[KIDX_HI -: KIDX_W];
    assign hdr_cnt    = mem_rdata[CNT_W-1:0];
    assign hdr_unused = ^mem_rdata[SPARE_HI:CNT_W];

    seg_plan u_plan (
        .seg      (r_q.seg),
        .exp_type (exp_type),
        .region   (region)
    );

    key_select #(.MASTER_W(MASTER_W), .KEY_W(KEY_W)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (key_load),
        .idx        (hdr_kidx),
        .master_key (master_key),
        .key        (dec_key)
    );

    sig_accum #(.W(WORD_W)) u_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sig_start),
        .update (sig_update),
        .word   (mem_rdata),
        .sig    (sig)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        mem_req    = 1'b0;
        cfg_valid  = 1'b0;
        dec_valid  = 1'b0;
        sig_start  = 1'b0;
        sig_update = 1'b0;
        key_load   = 1'b0;
        unique case (r_q.phase)
            PH_HDR: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.addr = r_q.addr + 1'b1;
                    if (hdr_type != exp_type) begin
                        r_d.phase   = PH_ERR;
                        r_d.err     = 1'b1;
                        r_d.err_seg = r_q.seg;
                    end else begin
                        sig_start = 1'b1;
                        key_load  = (hdr_type == TYPE_CIPHER);
                        r_d.enc   = (hdr_type == TYPE_CIPHER);
                        r_d.cnt   = hdr_cnt;
                        r_d.phase = (hdr_cnt == '0) ? PH_SIG : PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    sig_update = 1'b1;
                    r_d.addr   = r_q.addr + 1'b1;
                    r_d.word   = mem_rdata;
                    r_d.cnt    = r_q.cnt - 1'b1;
                    r_d.phase  = r_q.enc ? PH_DSEND : PH_CFG;
                end
            end
            PH_DSEND: begin
                dec_valid = 1'b1;
                if (dec_ready) r_d.phase = PH_DWAIT;
            end
            PH_DWAIT: begin
                if (dec_res_valid) begin
                    r_d.word  = dec_res_data;
                    r_d.phase = PH_CFG;
                end
            end
            PH_CFG: begin
                cfg_valid = 1'b1;
                if (cfg_ready) r_d.phase = (r_q.cnt == '0) ? PH_SIG : PH_BODY;
            end
            PH_SIG: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.addr = r_q.addr + 1'b1;
                    if (mem_rdata != sig) begin
                        r_d.phase   = PH_ERR;
                        r_d.err     = 1'b1;
                        r_d.err_seg = r_q.seg;
                    end else if (r_q.seg == LAST_SEG) begin
                        r_d.phase = PH_FIN;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.seg   = r_q.seg + 1'b1;
                        r_d.phase = PH_HDR;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_HDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr   = r_q.addr;
    assign cfg_data   = r_q.word;
    assign dec_data   = r_q.word;
    assign cfg_region = region;
    assign boot_done  = r_q.done;
    assign boot_err   = r_q.err;
    assign err_seg    = r_q.err_seg;
endmodule

// File: rtl/stage_boot_seq_chk.sv
module stage_boot_seq_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 16,
    parameter int KEY_W  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic [WORD_W-1:0] cfg_data,
    input logic [1:0]        cfg_region,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [WORD_W-1:0] dec_data,
    input logic [KEY_W-1:0]  dec_key,
    input logic              boot_done,
    input logic              boot_err,
    input logic [2:0]        err_seg
);
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && dec_valid)); // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data) && $stable(cfg_region)); // R7
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready |=> dec_valid && $stable(dec_data)); // R3
    AST_KEY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $stable(dec_key)); // R5
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> mem_addr == $past(mem_addr) + 1'b1); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> boot_err && $stable(err_seg)); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> !mem_req && !cfg_valid && !dec_valid); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !boot_done); // R10
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !boot_err && !mem_req && !cfg_valid); // R10
endmodule

bind stage_boot_seq stage_boot_seq_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_data   (cfg_data),
    .cfg_region (cfg_region),
    .dec_valid  (dec_valid),
    .dec_ready  (dec_ready),
    .dec_data   (dec_data),
    .dec_key    (dec_key),
    .boot_done  (boot_done),
    .boot_err   (boot_err),
    .err_seg    (err_seg)
);

// File: tb/stage_boot_seq_bench.sv
module stage_boot_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 32, ADDR_W = 16, CNT_W = 24, KEY_W = 128, MASTER_W = 1024;

    typedef struct packed {
        logic [7:0] c0, c1, c2, c3, c4;
        logic [2:0] k1, k3;
        logic [2:0] bad_seg;
        logic [1:0] bad_kind;   // 0 none, 1 signature, 2 header type
        logic       stall;
    } scen_t;

    localparam int NSCEN = 7;
    localparam scen_t SCEN [NSCEN] = '{
        '{8'd3, 8'd4, 8'd2, 8'd5, 8'd3, 3'd0, 3'd7, 3'd0, 2'd0, 1'b0},
        '{8'd6, 8'd8, 8'd5, 8'd7, 8'd4, 3'd2, 3'd5, 3'd0, 2'd0, 1'b1},
        '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 3'd7, 3'd0, 3'd0, 2'd0, 1'b1},
        '{8'd3, 8'd4, 8'd2, 8'd5, 8'd3, 3'd1, 3'd3, 3'd1, 2'd1, 1'b1},
        '{8'd3, 8'd4, 8'd2, 8'd5, 8'd3, 3'd1, 3'd3, 3'd2, 2'd2, 1'b0},
        '{8'd0, 8'd2, 8'd0, 8'd0, 8'd1, 3'd4, 3'd6, 3'd0, 2'd0, 1'b1},
        '{8'd2, 8'd3, 8'd2, 8'd3, 8'd6, 3'd5, 3'd2, 3'd4, 2'd1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic mem_req, mem_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic cfg_valid, cfg_ready = 1'b0;
    logic [WORD_W-1:0] cfg_data;
    logic [1:0] cfg_region;
    logic dec_valid, dec_ready = 1'b0;
    logic [WORD_W-1:0] dec_data;
    logic [KEY_W-1:0] dec_key;
    logic dec_res_valid = 1'b0;
    logic [WORD_W-1:0] dec_res_data = '0;
    logic [MASTER_W-1:0] master_key;
    logic boot_done, boot_err;
    logic [2:0] err_seg;

    stage_boot_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_W(KEY_W),
                     .MASTER_W(MASTER_W)) u_stage_boot_seq (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .cfg_region(cfg_region), .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_data(dec_data),
        .dec_key(dec_key), .dec_res_valid(dec_res_valid), .dec_res_data(dec_res_data),
        .master_key(master_key), .boot_done(boot_done), .boot_err(boot_err), .err_seg(err_seg));

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [1024];
    logic [31:0] exp_data [512];
    logic [1:0]  exp_reg  [512];
    logic [127:0] exp_key [512];
    logic [31:0] got_data [512];
    logic [1:0]  got_reg  [512];
    logic [127:0] got_key [512];
    int exp_n, exp_kn, got_n, got_kn, exp_fail_seg, addr_bad, done_cnt, next_addr;
    int checks = 0, fails = 0, cycles = 0;
    logic stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic pend = 1'b0;
    logic [31:0] pdata = '0;
    int dly = 0;

    initial begin
        for (int i = 0; i < MASTER_W/32; i++) master_key[i*32 +: 32] = 32'h9E3779B9 * (i + 1);
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rotl1(input logic [31:0] v);
        return {v[30:0], v[31]};
    endfunction

    // Image builder: expectations follow R1, R2, R3, R4, R5, R6, R12
    task automatic build(input scen_t sc);
        int a = 0;
        bit alive = 1;
        logic [7:0] cnts [5];
        cnts[0] = sc.c0; cnts[1] = sc.c1; cnts[2] = sc.c2; cnts[3] = sc.c3; cnts[4] = sc.c4;
        exp_n = 0; exp_kn = 0; exp_fail_seg = 7;
        for (int s = 0; s < 5; s++) begin
            logic [1:0] ty = (s == 4) ? 2'd2 : 2'(s % 2);
            logic [2:0] kx = (s == 1) ? sc.k1 : (s == 3) ? sc.k3 : 3'd0;
            logic [127:0] key = master_key[kx*128 +: 128];
            logic [1:0] rg = (s == 1) ? 2'd1 : (s == 3) ? 2'd2 : 2'd0;
            logic [31:0] hdr, sig, w;
            bit bad_hdr = (sc.bad_kind == 2 && sc.bad_seg == 3'(s));
            hdr = {bad_hdr ? 2'd3 : ty, kx, 3'b000, 24'(cnts[s])};
            if (alive && bad_hdr) begin alive = 0; exp_fail_seg = s; end
            mem[a++] = hdr;
            sig = hdr;
            for (int i = 0; i < cnts[s]; i++) begin
                w = {8'(s), 8'hC3, 16'(i * 37 + s * 5 + 1)};
                mem[a++] = w;
                sig = rotl1(sig) ^ w;
                if (alive) begin
                    exp_data[exp_n] = (ty == 2'd1) ? (w ^ key[31:0]) : w;
                    exp_reg[exp_n] = rg;
                    exp_n++;
                    if (ty == 2'd1) begin exp_key[exp_kn] = key; exp_kn++; end
                end
            end
            mem[a++] = sig ^ ((sc.bad_kind == 1 && sc.bad_seg == 3'(s)) ? 32'h1 : 32'h0);
            if (alive && sc.bad_kind == 1 && sc.bad_seg == 3'(s)) begin alive = 0; exp_fail_seg = s; end
        end
        for (int i = a; i < 1024; i++) mem[i] = 32'hDEAD0000 | i;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        got_n = 0; got_kn = 0; addr_bad = 0; done_cnt = 0; next_addr = 0;
        rst_n = 1'b1;
    endtask

    // Environment: memory, configuration port and engine models, driven away from the edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            mem_ack = 0; cfg_ready = 0; dec_ready = 0; dec_res_valid = 0; pend = 0;
        end else begin
            mem_ack = mem_req && (!stall || lfsr[0]);
            mem_rdata = mem[mem_addr[9:0]];
            if (mem_ack) begin
                if (int'(mem_addr) != next_addr) addr_bad++;
                next_addr++;
            end
            cfg_ready = !stall || lfsr[1] || lfsr[2];
            if (cfg_valid && cfg_ready) begin
                got_data[got_n] = cfg_data; got_reg[got_n] = cfg_region; got_n++;
            end
            dec_res_valid = 0;
            if (pend) begin
                if (dly <= 1) begin dec_res_valid = 1; dec_res_data = pdata; pend = 0; end
                else dly--;
            end
            dec_ready = !stall || lfsr[3];
            if (dec_valid && dec_ready) begin
                pend = 1; pdata = dec_data ^ dec_key[31:0]; dly = stall ? 3 : 1;
                got_key[got_kn] = dec_key; got_kn++;
            end
            if (boot_done) done_cnt++;
        end
    end

    task automatic run_scen(input scen_t sc, input int id);
        int guard = 0;
        int bad = 0;
        build(sc);
        stall = sc.stall;
        do_reset();
        while (!boot_done && !boot_err && guard < 20000) begin @(negedge clk); guard++; end
        repeat (30) @(negedge clk);
        if (exp_fail_seg == 7) begin
            // R10: exactly one done pulse, no error
            chk(done_cnt == 1 && !boot_err, $sformatf("R10 scen %0d done pulses", id), done_cnt, 1);
        end else begin
            // R1/R6/R9: error flag and failing segment
            chk(boot_err && err_seg == 3'(exp_fail_seg), $sformatf("R1/R6/R9 scen %0d err_seg", id),
                boot_err ? err_seg : 9, exp_fail_seg);
            chk(!mem_req && !cfg_valid && !dec_valid && done_cnt == 0,
                $sformatf("R9 scen %0d quiet after error", id), {mem_req, cfg_valid, dec_valid}, 0);
        end
        chk(got_n == exp_n, $sformatf("R7/R12 scen %0d write count", id), got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_data[i] != exp_data[i] || got_reg[i] != exp_reg[i]) bad++;
        chk(bad == 0, $sformatf("R2/R3/R4 scen %0d write content mismatches", id), bad, 0);
        bad = 0;
        for (int i = 0; i < exp_kn && i < got_kn; i++) if (got_key[i] != exp_key[i]) bad++;
        chk(bad == 0 && got_kn == exp_kn, $sformatf("R5 scen %0d engine keys", id), got_kn, exp_kn);
        chk(addr_bad == 0, $sformatf("R8 scen %0d address sequence", id), addr_bad, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        build(SCEN[0]);
        do_reset();
        chk(mem_req && mem_addr == 0 && !cfg_valid && !dec_valid && !boot_err && !boot_done,
            "R11 reset state", mem_addr, 0);

        for (int i = 0; i < NSCEN; i++) run_scen(SCEN[i], i);

        // R11: reset after an error clears it and restarts from address 0
        run_scen(SCEN[3], 100);
        do_reset();
        @(negedge clk);
        chk(!boot_err && mem_addr <= 1, "R11 error cleared by reset", boot_err, 0);
        run_scen(SCEN[0], 101);

        // R11: reset in the middle of a boot, then a full boot
        build(SCEN[1]);
        stall = 1'b1;
        do_reset();
        repeat (60) @(negedge clk);
        run_scen(SCEN[1], 102);

        // R12: empty bodies everywhere
        run_scen('{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 3'd3, 3'd1, 3'd0, 2'd0, 1'b1}, 103);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule